// File: doc/BRIEF.md
# Pipeline Operand Bypass and Stall Controller

This block is the hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Fetch and data accesses share one memory port. The block looks at three groups of fields:

- the two source register numbers of the instruction now in decode;
- the destination, write enable and load flag of the instruction in execute;
- the destination, write enable and memory-access flag of the instruction in the memory stage.

The bypass choice for each ALU operand is made while the consumer sits in decode. It is then registered, so it is ready when that instruction enters execute. At that point the nearer producer has moved into the EX/MEM register and the farther one into the MEM/WB register. A producer three slots ahead is in writeback during the consumer's decode. The register file writes in the first half of the cycle and reads in the second, so that value reaches the consumer without a bypass.

A stall is raised in two cases. The first is a load in execute whose destination the decode instruction reads. The second is a load or store in the memory stage that takes the shared port away from fetch. When the shared port is configured off, only the first case applies. When both cases occur in the same cycle, one stall covers both. During a stall the PC and the fetch/decode register hold their contents, and the instruction entering execute is turned into a bubble. No data stream passes through the block, so it has no valid/ready handshake. Every pin is a plain control level.

Top module: `hazard_fwd_ctrl`

## Requirements
- R1: If a decode source is nonzero and equals the execute-stage destination with its write enable set, then one cycle later that operand's select reads 2'b10 (take from EX/MEM).
- R2: If a decode source is nonzero and equals only the memory-stage destination with its write enable set, then one cycle later that operand's select reads 2'b01 (take from MEM/WB).
- R3: If neither stage matches a decode source, then one cycle later the select reads 2'b00 (register file). This covers a producer three slots ahead.
- R4: When both stages match a source, the select is 2'b10: the execute-stage producer wins.
- R5: Source register 0 never causes a bypass or a stall. A stage whose write enable is low never matches.
- R6: A load in execute whose nonzero destination equals either decode source raises pc_hold, ifid_hold and idex_bubble in the same cycle.
- R7: A load in the memory stage that matches a decode source produces select 2'b01 and raises no stall of its own when SHARED_PORT is 0.
- R8: The three stall outputs always agree. In the cycle after a stall, both selects read 2'b00, because execute then holds a bubble.
- R9: With SHARED_PORT set to 1, a memory-stage load or store (mem_access high) raises the stall in the same cycle.
- R10: A load-use hazard and a port conflict in the same cycle give exactly the same single stall as either one alone.
- R11: After reset both selects read 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_rs1 | input | REG_W | First source register of the decode instruction |
| id_rs2 | input | REG_W | Second source register of the decode instruction |
| ex_rd | input | REG_W | Destination of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | REG_W | Destination of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_access | input | 1 | Memory-stage instruction uses the memory port |
| fwd_a | output | 2 | Operand A select: 00 register file, 01 MEM/WB, 10 EX/MEM |
| fwd_b | output | 2 | Operand B select, same encoding |
| pc_hold | output | 1 | Keep the PC unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a bubble into the decode/execute register |

## Verification
The bench builds two instances that share one set of stimulus. Both use REG_W of 3. Eight registers make random source/destination collisions, double matches and register-0 cases frequent, where a full-width register field would make them rare. One instance has SHARED_PORT at 1 and the other at 0. This brings both the structural stall and the plain bypass-from-load path (the path a port stall would otherwise mask) within reach in the same cycles.

// File: rtl/hazard_ctrl_pkg.sv
`timescale 1ns/1ps
package hazard_ctrl_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_pick.sv
`timescale 1ns/1ps
// Chooses the bypass source for one operand while its consumer is in decode.
// "near" is the stage one slot ahead, "far" is two slots ahead.
module hz_fwd_pick
  import hazard_ctrl_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_reg,
  input  logic [REG_W-1:0] near_rd,
  input  logic             near_wen,
  input  logic [REG_W-1:0] far_rd,
  input  logic             far_wen,
  output fwd_sel_e         sel
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic src_live;
  logic near_hit;
  logic far_hit;

  always_comb begin
    src_live = (src_reg != ZERO_REG);
    near_hit = src_live && near_wen && (near_rd == src_reg);
    far_hit  = src_live && far_wen && (far_rd == src_reg);
    if (near_hit)     sel = FWD_MEM;
    else if (far_hit) sel = FWD_WB;
    else              sel = FWD_RF;
  end
endmodule

// File: rtl/hz_stall_unit.sv
`timescale 1ns/1ps
// Merges the load-use and shared-port stall causes into one request.
module hz_stall_unit #(
  parameter int REG_W       = 5,
  parameter int SHARED_PORT = 1
) (
  input  logic [REG_W-1:0] rs1,
  input  logic [REG_W-1:0] rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic             mem_access,
  output logic             stall
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;
  localparam logic PORT_SHARED = (SHARED_PORT != 0);

  logic load_use;
  logic port_clash;

  always_comb begin
    load_use   = ex_load && ex_wen && (ex_rd != ZERO_REG) &&
                 ((ex_rd == rs1) || (ex_rd == rs2));
    port_clash = PORT_SHARED && mem_access;
    stall      = load_use || port_clash;
  end
endmodule

// File: rtl/hazard_fwd_ctrl.sv
`timescale 1ns/1ps
module hazard_fwd_ctrl
  import hazard_ctrl_pkg::*;
#(
  parameter int REG_W       = 5,
  parameter int SHARED_PORT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wen,
  input  logic             mem_access,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             idex_bubble
);
  localparam int N_OPND = 2;
  localparam int SEL_W  = 2;

  logic [REG_W-1:0]       src [N_OPND];
  fwd_sel_e               sel_next [N_OPND];
  logic [N_OPND*SEL_W-1:0] sel_q;
  logic                   stall;

  assign src[0] = id_rs1;
  assign src[1] = id_rs2;

  hz_stall_unit #(
    .REG_W      (REG_W),
    .SHARED_PORT(SHARED_PORT)
  ) u_stall (
    .rs1       (id_rs1),
    .rs2       (id_rs2),
    .ex_rd     (ex_rd),
    .ex_wen    (ex_wen),
    .ex_load   (ex_load),
    .mem_access(mem_access),
    .stall     (stall)
  );

  generate
    for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
      hz_fwd_pick #(.REG_W(REG_W)) u_pick (
        .src_reg (src[i]),
        .near_rd (ex_rd),
        .near_wen(ex_wen),
        .far_rd  (mem_rd),
        .far_wen (mem_wen),
        .sel     (sel_next[i])
      );
    end
  endgenerate

  // Decision made in decode, presented while the consumer is in execute.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else begin
      for (int i = 0; i < N_OPND; i++) begin
        sel_q[i*SEL_W +: SEL_W] <= stall ? FWD_RF : sel_next[i];
      end
    end
  end

  assign fwd_a       = sel_q[0 +: SEL_W];
  assign fwd_b       = sel_q[SEL_W +: SEL_W];
  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;
endmodule

// File: rtl/hz_ctrl_checker.sv
`timescale 1ns/1ps
module hz_ctrl_checker #(
  parameter int REG_W       = 5,
  parameter int SHARED_PORT = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] id_rs1,
  input logic [REG_W-1:0] id_rs2,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_wen,
  input logic             ex_load,
  input logic [REG_W-1:0] mem_rd,
  input logic             mem_wen,
  input logic             mem_access,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b,
  input logic             pc_hold,
  input logic             ifid_hold,
  input logic             idex_bubble
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  a_r1_near_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!idex_bubble && ex_wen && id_rs1 != ZERO_REG && ex_rd == id_rs1) |=> (fwd_a == 2'b10));

  a_r2_far_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!idex_bubble && mem_wen && id_rs2 != ZERO_REG && mem_rd == id_rs2 &&
     !(ex_wen && ex_rd == id_rs2)) |=> (fwd_b == 2'b01));

  a_r3_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b11) && (fwd_b != 2'b11));

  a_r5_zero_source: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs1 == ZERO_REG) |=> (fwd_a == 2'b00));

  a_r5_no_writers: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_wen && !mem_wen) |=> (fwd_a == 2'b00 && fwd_b == 2'b00));

  a_r6_load_use: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_load && ex_wen && ex_rd != ZERO_REG && (ex_rd == id_rs1 || ex_rd == id_rs2))
      |-> (pc_hold && ifid_hold && idex_bubble));

  a_r8_bubble_clears: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |=> (fwd_a == 2'b00 && fwd_b == 2'b00));

  a_r9_port_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (SHARED_PORT != 0 && mem_access) |-> (pc_hold && ifid_hold));
endmodule

bind hazard_fwd_ctrl hz_ctrl_checker #(
  .REG_W      (REG_W),
  .SHARED_PORT(SHARED_PORT)
) u_hz_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .id_rs1     (id_rs1),
  .id_rs2     (id_rs2),
  .ex_rd      (ex_rd),
  .ex_wen     (ex_wen),
  .ex_load    (ex_load),
  .mem_rd     (mem_rd),
  .mem_wen    (mem_wen),
  .mem_access (mem_access),
  .fwd_a      (fwd_a),
  .fwd_b      (fwd_b),
  .pc_hold    (pc_hold),
  .ifid_hold  (ifid_hold),
  .idex_bubble(idex_bubble)
);

// File: tb/test_hazard_fwd_ctrl.sv
`timescale 1ns/1ps
module test_hazard_fwd_ctrl;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0;
  logic ex_wen = 1'b0, ex_load = 1'b0, mem_wen = 1'b0, mem_access = 1'b0;
  logic [1:0] s_fa, s_fb, p_fa, p_fb;
  logic s_pc, s_ifid, s_bub, p_pc, p_ifid, p_bub;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hazard_fwd_ctrl #(.REG_W(RW), .SHARED_PORT(1)) i_hazard_fwd_ctrl (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_access(mem_access),
    .fwd_a(s_fa), .fwd_b(s_fb), .pc_hold(s_pc), .ifid_hold(s_ifid), .idex_bubble(s_bub));

  hazard_fwd_ctrl #(.REG_W(RW), .SHARED_PORT(0)) i_hazard_fwd_ctrl_split (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_access(mem_access),
    .fwd_a(p_fa), .fwd_b(p_fb), .pc_hold(p_pc), .ifid_hold(p_ifid), .idex_bubble(p_bub));

  function automatic bit exp_load_use();
    return ex_load && ex_wen && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
  endfunction

  function automatic bit exp_stall(input bit shared);
    return exp_load_use() || (shared && mem_access);
  endfunction

  function automatic logic [1:0] exp_sel(input logic [RW-1:0] s, input bit stall);
    if (stall || s == 0) return 2'b00;
    if (ex_wen && ex_rd == s) return 2'b10;
    if (mem_wen && mem_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string sel_tag(input logic [RW-1:0] s, input bit stall);
    bit nh, fh;
    nh = ex_wen && ex_rd == s;
    fh = mem_wen && mem_rd == s;
    if (stall) return "R8";
    if (s == 0) return "R5";
    if (nh && fh) return "R4";
    if (nh) return "R1";
    if (fh) return mem_access ? "R7" : "R2";
    if (ex_rd == s || mem_rd == s) return "R5";
    return "R3";
  endfunction

  function automatic string stall_tag(input bit shared);
    bit lu, pt;
    lu = exp_load_use();
    pt = shared && mem_access;
    if (lu && pt) return "R10";
    if (pt) return "R9";
    if (lu) return "R6";
    return "R8";
  endfunction

  task automatic check2(input string tag, input string what, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic check_stall(input string tag, input string what, input logic a, input logic b, input logic c, input bit exp);
    checks++;
    if (a !== exp || b !== exp || c !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b%b%b expected=%b%b%b", tag, what, a, b, c, exp, exp, exp);
    end
  endtask

  // Drive one stage snapshot at the falling edge, check the stall at once,
  // and the registered selects just after the next rising edge.
  task automatic step(input logic [RW-1:0] r1, input logic [RW-1:0] r2,
                      input logic [RW-1:0] erd, input bit ew, input bit el,
                      input logic [RW-1:0] mrd, input bit mw, input bit ma);
    bit ss, ps;
    logic [1:0] sa, sb, pa, pb;
    string ta_s, tb_s, ta_p, tb_p;
    id_rs1 = r1; id_rs2 = r2; ex_rd = erd; ex_wen = ew; ex_load = el;
    mem_rd = mrd; mem_wen = mw; mem_access = ma;
    #1;
    ss = exp_stall(1'b1);
    ps = exp_stall(1'b0);
    check_stall(stall_tag(1'b1), "shared stall", s_pc, s_ifid, s_bub, ss);
    check_stall(stall_tag(1'b0), "split stall", p_pc, p_ifid, p_bub, ps);
    sa = exp_sel(r1, ss); sb = exp_sel(r2, ss);
    pa = exp_sel(r1, ps); pb = exp_sel(r2, ps);
    ta_s = sel_tag(r1, ss); tb_s = sel_tag(r2, ss);
    ta_p = sel_tag(r1, ps); tb_p = sel_tag(r2, ps);
    @(posedge clk); #2;
    check2(ta_s, "shared fwd_a", s_fa, sa);
    check2(tb_s, "shared fwd_b", s_fb, sb);
    check2(ta_p, "split fwd_a", p_fa, pa);
    check2(tb_p, "split fwd_b", p_fb, pb);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11: reset state of the selects
    check2("R11", "reset fwd_a", s_fa, 2'b00);
    check2("R11", "reset fwd_b", p_fb, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);

    // Writer followed by four readers of r1 (distances 1, 2, 3, 4)
    step(3'd1, 3'd5, 3'd1, 1, 0, 3'd0, 0, 0); // R1
    step(3'd1, 3'd7, 3'd4, 1, 0, 3'd1, 1, 0); // R2
    step(3'd1, 3'd3, 3'd6, 1, 0, 3'd4, 1, 0); // R3
    step(3'd1, 3'd5, 3'd2, 1, 0, 3'd6, 1, 0); // R3
    // Load then dependent at distance 1: load-use stall, then bubble ahead
    step(3'd1, 3'd7, 3'd1, 1, 1, 3'd0, 0, 0); // R6
    step(3'd1, 3'd7, 3'd0, 0, 0, 3'd1, 1, 1); // R9 shared, R7 split
    // Load at distance 2 with no port sharing
    step(3'd2, 3'd1, 3'd5, 1, 0, 3'd1, 1, 1); // R7
    // Load at distance 3: nothing in flight matches
    step(3'd1, 3'd6, 3'd5, 1, 0, 3'd3, 1, 0); // R3
    // Both stages write the same register
    step(3'd2, 3'd2, 3'd2, 1, 0, 3'd2, 1, 0); // R4
    // Register 0 and disabled writers
    step(3'd0, 3'd0, 3'd0, 1, 1, 3'd0, 1, 1); // R5
    step(3'd3, 3'd4, 3'd3, 0, 1, 3'd4, 0, 0); // R5
    // Load-use and port conflict together
    step(3'd6, 3'd2, 3'd2, 1, 1, 3'd5, 0, 1); // R10
    step(3'd6, 3'd2, 3'd2, 1, 0, 3'd6, 1, 0);

    for (int n = 0; n < 3000; n++) begin
      logic [RW-1:0] a, b, e, m;
      bit ew, el, mw, ma;
      a = RW'($urandom_range(0, 7));
      b = RW'($urandom_range(0, 7));
      e = RW'($urandom_range(0, 7));
      m = RW'($urandom_range(0, 7));
      ew = ($urandom_range(0, 3) != 0);
      el = ew && ($urandom_range(0, 2) == 0);
      mw = ($urandom_range(0, 3) != 0);
      ma = ($urandom_range(0, 2) == 0);
      step(a, b, e, ew, el, m, mw, ma);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule